// File: doc/BRIEF.md
# Indexed Configuration Port Controller

This block holds the configuration state of a multi-function I/O controller and exposes it to a byte-wide host bus through two addresses: a configuration/index port at a strapped base address and a data port one address above it. Following reset the block sits in run mode, where the host cannot see or change any configuration state. Two back-to-back writes of the unlock key to the base address open configuration mode. The host then writes a register number to the index port and reads or writes that register through the data port. A lock key written to the base address closes configuration mode again.

Identification, revision, the logical-device selector and a power-enable register are global. All other registers belong to one of nine per-device banks. The logical-device selector chooses which bank the shared bank indexes reach. For each device the block drives an activate bit, a 16-bit I/O base, a primary interrupt select and one secondary select. The secondary select is the second interrupt for the keyboard device and the DMA channel for the floppy and parallel devices.

Top module: `cfg_port_ctrl`

## Requirements
- R1: Configuration mode opens only when 0x55 is written to the base address on two consecutive host writes. A single 0x55 does not open it. Any other host write between the two 0x55 writes restarts the sequence. Once configuration mode is open, a 0x55 written to the base address is taken as an index value.
- R2: In configuration mode, writing 0xAA to the base address returns the block to run mode and leaves the index unchanged.
- R3: In run mode, reads of either port return 0xFF. In run mode, writes to the base or data port change no register, no index and no output.
- R4: With `base_sel`=0 the base address is 0x3F0, and with `base_sel`=1 it is 0x370. The data port is always the base address plus one. Accesses to any other address have no effect, and reads there return 0xFF.
- R5: Index 0x20 reads 0x02. Index 0x21 reads the revision byte, which is 0x01 by default.
- R6: Index 0x07 holds the logical device number and reads back its value. Indexes 0x30 and above reach only the bank of the selected device. Each bank keeps its contents while other banks are selected.
- R7: In each bank, index 0x30 bit 0 is the activate bit and appears on `dev_act[n]`. Index 0x60 is the I/O base high byte and index 0x61 the low byte; together they appear on `dev_base[16n+:16]`. Index 0x70 is the primary interrupt select and appears on `dev_irq[8n+:8]`.
- R8: Index 0x72 exists only in bank 7, and index 0x74 exists only in banks 0 and 3. Each drives `dev_aux[8n+:8]`. In any other bank these indexes read 0x00, and writes to them have no effect.
- R9: Index 0x22 bits 0 to 5 are the power enables for devices 0 to 5 and appear on `pwr_en`. Bits 6 and 7 read 0.
- R10: In bank 0, indexes 0x90 and 0x91 are read/write registers that return the last value written.
- R11: An unimplemented index reads 0x00. Any bank index reads 0x00 when the device number is 9 or above, and writes to such indexes have no effect.
- R12: Read data appears on `rdata` one clock after the cycle with `rd_en`. An index-port read in configuration mode returns the current index. Reset clears all banks, selects and enables and puts the block in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 1 | Base address strap: 0 selects 0x3F0, 1 selects 0x370 |
| addr | input | 16 | Host I/O address |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| dev_act | output | 9 | Activate bit per logical device |
| dev_base | output | 144 | 16-bit I/O base per device, device n at bits 16n+15:16n |
| dev_irq | output | 72 | Primary interrupt select per device, device n at bits 8n+7:8n |
| dev_aux | output | 72 | Secondary select per device (keyboard interrupt 2, floppy/parallel DMA), zero for the others |
| pwr_en | output | 6 | Power enables for devices 0 to 5 |

## Verification
A write changes a register at the clock edge that samples it, so the outputs it drives show the new value at the next falling edge. The bench checks them there. A read result appears on `rdata` one edge after the cycle with `rd_en`, so every read task raises the strobe for one cycle and samples at the falling edge that follows. Key and lock writes change the mode at the edge that samples them. The bench therefore performs the next access only in a later cycle. The clocked properties use `|=>` for the same one-edge delay.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int NDEV = 9;
  localparam int DW   = 8;

  localparam logic [DW-1:0] KEY_OPEN  = 8'h55;
  localparam logic [DW-1:0] KEY_CLOSE = 8'hAA;

  localparam logic [DW-1:0] IX_LDN   = 8'h07;
  localparam logic [DW-1:0] IX_IDENT = 8'h20;
  localparam logic [DW-1:0] IX_REVN  = 8'h21;
  localparam logic [DW-1:0] IX_POWER = 8'h22;
  localparam logic [DW-1:0] IX_BANK0 = 8'h30;
  localparam logic [DW-1:0] IX_ACT   = 8'h30;
  localparam logic [DW-1:0] IX_BHI   = 8'h60;
  localparam logic [DW-1:0] IX_BLO   = 8'h61;
  localparam logic [DW-1:0] IX_IRQA  = 8'h70;
  localparam logic [DW-1:0] IX_IRQB  = 8'h72;
  localparam logic [DW-1:0] IX_DMA   = 8'h74;
  localparam logic [DW-1:0] IX_FMODE = 8'h90;
  localparam logic [DW-1:0] IX_FOPT  = 8'h91;

  localparam int DEV_FLOPPY = 0;
  localparam int DEV_PARLL  = 3;
  localparam int DEV_KEYB   = 7;

  function automatic bit dev_has_irqb(int d);
    return d == DEV_KEYB;
  endfunction

  function automatic bit dev_has_dma(int d);
    return (d == DEV_FLOPPY) || (d == DEV_PARLL);
  endfunction

  function automatic bit dev_has_fdd(int d);
    return d == DEV_FLOPPY;
  endfunction

  function automatic logic [15:0] strap_base(logic sel, logic [15:0] a, logic [15:0] b);
    return sel ? b : a;
  endfunction
endpackage

// File: rtl/cfgp_unlock.sv
module cfgp_unlock
  import cfgp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  output logic          cfg_mode,
  output logic          open_evt,
  output logic          close_evt
);
  logic armed;

  assign open_evt  = !cfg_mode && key_wr && armed && (wdata == KEY_OPEN);
  assign close_evt = cfg_mode && key_wr && (wdata == KEY_CLOSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= 1'b0;
      armed    <= 1'b0;
    end else if (cfg_mode) begin
      armed <= 1'b0;
      if (close_evt) cfg_mode <= 1'b0;
    end else if (open_evt) begin
      cfg_mode <= 1'b1;
      armed    <= 1'b0;
    end else if (key_wr) begin
      armed <= (wdata == KEY_OPEN);
    end else if (dat_wr) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
  import cfgp_pkg::*;
#(
  parameter int DEV = 0,
  parameter int IOW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [DW-1:0]  idx,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rd,
  output logic           act,
  output logic [IOW-1:0] iobase,
  output logic [DW-1:0]  irq,
  output logic [DW-1:0]  aux
);
  localparam bit HAS_B = dev_has_irqb(DEV);
  localparam bit HAS_D = dev_has_dma(DEV);
  localparam bit HAS_F = dev_has_fdd(DEV);

  logic [DW-1:0] fmode, fopt;
  logic          aux_hit;

  assign aux_hit = (HAS_B && idx == IX_IRQB) || (HAS_D && idx == IX_DMA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= 1'b0;
      iobase <= '0;
      irq    <= '0;
      aux    <= '0;
    end else if (we) begin
      if (idx == IX_ACT)  act               <= wdata[0];
      if (idx == IX_BHI)  iobase[IOW-1:DW]  <= wdata;
      if (idx == IX_BLO)  iobase[DW-1:0]    <= wdata;
      if (idx == IX_IRQA) irq               <= wdata;
      if (aux_hit)        aux               <= wdata;
    end
  end

  generate
    if (HAS_F) begin : g_fdd
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          fmode <= '0;
          fopt  <= '0;
        end else if (we) begin
          if (idx == IX_FMODE) fmode <= wdata;
          if (idx == IX_FOPT)  fopt  <= wdata;
        end
      end
    end else begin : g_nofdd
      assign fmode = '0;
      assign fopt  = '0;
    end
  endgenerate

  always_comb begin
    rd = '0;
    if (idx == IX_ACT)                rd = DW'(act);
    if (idx == IX_BHI)                rd = iobase[IOW-1:DW];
    if (idx == IX_BLO)                rd = iobase[DW-1:0];
    if (idx == IX_IRQA)               rd = irq;
    if (aux_hit)                      rd = aux;
    if (HAS_F && idx == IX_FMODE)     rd = fmode;
    if (HAS_F && idx == IX_FOPT)      rd = fopt;
  end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfgp_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          IOW      = 16,
  parameter int          PWR_BITS = 6,
  parameter logic [15:0] BASE_A   = 16'h03F0,
  parameter logic [15:0] BASE_B   = 16'h0370,
  parameter logic [7:0]  ID_VAL   = 8'h02,
  parameter logic [7:0]  REV_VAL  = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  base_sel,
  input  logic [AW-1:0]         addr,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output logic [NDEV-1:0]       dev_act,
  output logic [NDEV*IOW-1:0]   dev_base,
  output logic [NDEV*DW-1:0]    dev_irq,
  output logic [NDEV*DW-1:0]    dev_aux,
  output logic [PWR_BITS-1:0]   pwr_en
);
  localparam int LDW = $clog2(NDEV + 1);

  logic [AW-1:0]  base_adr;
  logic           hit_key, hit_dat;
  logic           key_wr, dat_wr;
  logic           cfg_mode, open_evt, close_evt;
  logic           idx_wr, reg_wr, bank_idx;
  logic [DW-1:0]  idx_q;
  logic [LDW-1:0] ldn_q;
  logic [DW-1:0]  cfg_rd, bank_mux;
  logic [DW-1:0]  bank_rd [NDEV];
  logic [NDEV-1:0] bank_we;

  assign base_adr = AW'(strap_base(base_sel, BASE_A, BASE_B));
  assign hit_key  = (addr == base_adr);
  assign hit_dat  = (addr == base_adr + AW'(1));
  assign key_wr   = wr_en && hit_key;
  assign dat_wr   = wr_en && hit_dat;
  assign idx_wr   = key_wr && cfg_mode && !close_evt;
  assign reg_wr   = dat_wr && cfg_mode;
  assign bank_idx = (idx_q >= IX_BANK0);

  cfgp_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .dat_wr   (dat_wr),
    .wdata    (wdata),
    .cfg_mode (cfg_mode),
    .open_evt (open_evt),
    .close_evt(close_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ldn_q  <= '0;
      pwr_en <= '0;
    end else begin
      if (idx_wr) idx_q <= wdata;
      if (reg_wr && idx_q == IX_LDN)   ldn_q  <= wdata[LDW-1:0];
      if (reg_wr && idx_q == IX_POWER) pwr_en <= wdata[PWR_BITS-1:0];
    end
  end

  genvar d;
  generate
    for (d = 0; d < NDEV; d++) begin : g_bank
      assign bank_we[d] = reg_wr && bank_idx && (ldn_q == LDW'(d));
      cfgp_bank #(.DEV(d), .IOW(IOW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bank_we[d]),
        .idx    (idx_q),
        .wdata  (wdata),
        .rd     (bank_rd[d]),
        .act    (dev_act[d]),
        .iobase (dev_base[d*IOW +: IOW]),
        .irq    (dev_irq[d*DW +: DW]),
        .aux    (dev_aux[d*DW +: DW])
      );
    end
  endgenerate

  always_comb begin
    bank_mux = '0;
    for (int k = 0; k < NDEV; k++)
      if (ldn_q == LDW'(k)) bank_mux = bank_rd[k];
  end

  always_comb begin
    case (idx_q)
      IX_LDN:   cfg_rd = DW'(ldn_q);
      IX_IDENT: cfg_rd = ID_VAL;
      IX_REVN:  cfg_rd = REV_VAL;
      IX_POWER: cfg_rd = DW'(pwr_en);
      default:  cfg_rd = bank_idx ? bank_mux : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '1;
    else if (rd_en) begin
      if (cfg_mode && hit_dat)      rdata <= cfg_rd;
      else if (cfg_mode && hit_key) rdata <= idx_q;
      else                          rdata <= '1;
    end
  end
endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk
  import cfgp_pkg::*;
#(
  parameter int AW = 16,
  parameter int IOW = 16,
  parameter int PWR_BITS = 6,
  parameter logic [15:0] BASE_A = 16'h03F0,
  parameter logic [15:0] BASE_B = 16'h0370
) (
  input logic                clk,
  input logic                rst_n,
  input logic                base_sel,
  input logic [AW-1:0]       addr,
  input logic                wr_en,
  input logic                rd_en,
  input logic [DW-1:0]       wdata,
  input logic [DW-1:0]       rdata,
  input logic                cfg_mode,
  input logic [DW-1:0]       idx_q,
  input logic [NDEV-1:0]     dev_act,
  input logic [NDEV*IOW-1:0] dev_base,
  input logic [NDEV*DW-1:0]  dev_irq,
  input logic [NDEV*DW-1:0]  dev_aux,
  input logic [PWR_BITS-1:0] pwr_en
);
  logic [AW-1:0] cfg_adr;
  assign cfg_adr = AW'(base_sel ? BASE_B : BASE_A);

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> $past(wr_en && addr == cfg_adr && wdata == KEY_OPEN)); // R1

  AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && wr_en && addr == cfg_adr && wdata == KEY_CLOSE) |=> !cfg_mode); // R2

  AST_RUN_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && rd_en && addr == cfg_adr + AW'(1)) |=> rdata == 8'hFF); // R3

  AST_RUN_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> ($stable(dev_act) && $stable(dev_base) && $stable(dev_irq)
                   && $stable(dev_aux) && $stable(pwr_en) && $stable(idx_q))); // R3

  AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && rd_en && addr == cfg_adr + AW'(1) && idx_q == IX_IDENT) |=> rdata == 8'h02); // R5

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R12
endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(
  .AW(AW), .IOW(IOW), .PWR_BITS(PWR_BITS), .BASE_A(BASE_A), .BASE_B(BASE_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .addr(addr), .wr_en(wr_en),
  .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .cfg_mode(cfg_mode), .idx_q(idx_q),
  .dev_act(dev_act), .dev_base(dev_base), .dev_irq(dev_irq), .dev_aux(dev_aux),
  .pwr_en(pwr_en)
);

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_sel = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [8:0]  dev_act;
  logic [143:0] dev_base;
  logic [71:0] dev_irq, dev_aux;
  logic [5:0]  pwr_en;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .dev_act(dev_act),
    .dev_base(dev_base), .dev_irq(dev_irq), .dev_aux(dev_aux), .pwr_en(pwr_en)
  );

  typedef struct packed {
    logic       rd;
    logic       dp;
    logic [7:0] v;
    logic [7:0] e;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 69;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,8'h00,8'hFF,4'd3},  // R3 run-mode data read
    '{1'b0,1'b0,8'h55,8'h00,4'd1},
    '{1'b0,1'b0,8'h12,8'h00,4'd1},  // R1 breaks sequence
    '{1'b0,1'b0,8'h55,8'h00,4'd1},
    '{1'b1,1'b1,8'h00,8'hFF,4'd1},  // R1 one key: still locked
    '{1'b0,1'b0,8'h55,8'h00,4'd1},  // R1 second key opens
    '{1'b0,1'b0,8'h20,8'h00,4'd5},
    '{1'b1,1'b1,8'h00,8'h02,4'd5},  // R5 ident
    '{1'b0,1'b0,8'h21,8'h00,4'd5},
    '{1'b1,1'b1,8'h00,8'h01,4'd5},  // R5 revision
    '{1'b1,1'b0,8'h00,8'h21,4'd12}, // R12 index readback
    '{1'b0,1'b0,8'h07,8'h00,4'd6},
    '{1'b0,1'b1,8'h04,8'h00,4'd6},
    '{1'b1,1'b1,8'h00,8'h04,4'd6},  // R6 ldn readback
    '{1'b0,1'b0,8'h30,8'h00,4'd7},
    '{1'b0,1'b1,8'h01,8'h00,4'd7},
    '{1'b1,1'b1,8'h00,8'h01,4'd7},  // R7 activate
    '{1'b0,1'b0,8'h60,8'h00,4'd7},
    '{1'b0,1'b1,8'h03,8'h00,4'd7},
    '{1'b1,1'b1,8'h00,8'h03,4'd7},
    '{1'b0,1'b0,8'h61,8'h00,4'd7},
    '{1'b0,1'b1,8'hF8,8'h00,4'd7},
    '{1'b1,1'b1,8'h00,8'hF8,4'd7},
    '{1'b0,1'b0,8'h70,8'h00,4'd7},
    '{1'b0,1'b1,8'h04,8'h00,4'd7},
    '{1'b1,1'b1,8'h00,8'h04,4'd7},
    '{1'b0,1'b0,8'h74,8'h00,4'd8},
    '{1'b0,1'b1,8'h05,8'h00,4'd8},
    '{1'b1,1'b1,8'h00,8'h00,4'd8},  // R8 no DMA in bank 4
    '{1'b0,1'b0,8'h55,8'h00,4'd1},  // R1 0x55 is an index now
    '{1'b1,1'b0,8'h00,8'h55,4'd1},
    '{1'b1,1'b1,8'h00,8'h00,4'd11}, // R11 unimplemented
    '{1'b0,1'b0,8'h07,8'h00,4'd8},
    '{1'b0,1'b1,8'h07,8'h00,4'd8},
    '{1'b0,1'b0,8'h72,8'h00,4'd8},
    '{1'b0,1'b1,8'h0C,8'h00,4'd8},
    '{1'b1,1'b1,8'h00,8'h0C,4'd8},  // R8 keyboard irq2
    '{1'b0,1'b0,8'h07,8'h00,4'd10},
    '{1'b0,1'b1,8'h00,8'h00,4'd10},
    '{1'b0,1'b0,8'h90,8'h00,4'd10},
    '{1'b0,1'b1,8'h0E,8'h00,4'd10},
    '{1'b1,1'b1,8'h00,8'h0E,4'd10}, // R10 mode
    '{1'b0,1'b0,8'h91,8'h00,4'd10},
    '{1'b0,1'b1,8'h5A,8'h00,4'd10},
    '{1'b1,1'b1,8'h00,8'h5A,4'd10}, // R10 option
    '{1'b0,1'b0,8'h74,8'h00,4'd8},
    '{1'b0,1'b1,8'h02,8'h00,4'd8},
    '{1'b1,1'b1,8'h00,8'h02,4'd8},  // R8 floppy DMA
    '{1'b0,1'b0,8'h07,8'h00,4'd8},
    '{1'b0,1'b1,8'h03,8'h00,4'd8},
    '{1'b0,1'b0,8'h74,8'h00,4'd8},
    '{1'b0,1'b1,8'h03,8'h00,4'd8},
    '{1'b1,1'b1,8'h00,8'h03,4'd8},  // R8 parallel DMA
    '{1'b0,1'b0,8'h22,8'h00,4'd9},
    '{1'b0,1'b1,8'hFF,8'h00,4'd9},
    '{1'b1,1'b1,8'h00,8'h3F,4'd9},  // R9 power bits
    '{1'b0,1'b0,8'h07,8'h00,4'd11},
    '{1'b0,1'b1,8'h09,8'h00,4'd11},
    '{1'b0,1'b0,8'h30,8'h00,4'd11},
    '{1'b0,1'b1,8'h01,8'h00,4'd11},
    '{1'b1,1'b1,8'h00,8'h00,4'd11}, // R11 device 9
    '{1'b0,1'b0,8'h07,8'h00,4'd6},
    '{1'b0,1'b1,8'h04,8'h00,4'd6},
    '{1'b0,1'b0,8'h30,8'h00,4'd6},
    '{1'b1,1'b1,8'h00,8'h01,4'd6},  // R6 bank 4 retained
    '{1'b0,1'b0,8'hAA,8'h00,4'd2},  // R2 close
    '{1'b1,1'b1,8'h00,8'hFF,4'd2},
    '{1'b0,1'b0,8'h61,8'h00,4'd3},  // R3 ignored index write
    '{1'b0,1'b1,8'h00,8'h00,4'd3}   // R3 ignored data write
  };

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, 256'(rdata), 256'(e));
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 act after reset", 256'(dev_act), 256'(0));
    check("R12 base after reset", 256'(dev_base), 256'(0));
    check("R12 pwr after reset", 256'(pwr_en), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rd)
        bus_rd(16'h03F0 + 16'(TBL[i].dp), TBL[i].e, $sformatf("R%0d table step %0d", TBL[i].rq, i));
      else
        bus_wr(16'h03F0 + 16'(TBL[i].dp), TBL[i].v);
    end

    // R7 R8 R9 outputs after the table
    check("R7 dev_act", 256'(dev_act), 256'(9'b0_0001_0000));
    check("R7 dev4 base", 256'(dev_base[4*16 +: 16]), 256'(16'h03F8));
    check("R7 dev4 irq", 256'(dev_irq[4*8 +: 8]), 256'(8'h04));
    check("R8 kbd aux", 256'(dev_aux[7*8 +: 8]), 256'(8'h0C));
    check("R8 floppy aux", 256'(dev_aux[0 +: 8]), 256'(8'h02));
    check("R8 parallel aux", 256'(dev_aux[3*8 +: 8]), 256'(8'h03));
    check("R8 serial aux", 256'(dev_aux[4*8 +: 8]), 256'(8'h00));
    check("R9 pwr_en", 256'(pwr_en), 256'(6'h3F));

    // R3 run-mode writes left nothing changed
    bus_wr(16'h03F0, 8'h55);
    bus_wr(16'h03F0, 8'h55);
    bus_rd(16'h03F0, 8'h30, "R3 index kept through run mode");
    bus_rd(16'h03F1, 8'h01, "R3 activate kept through run mode");
    bus_wr(16'h03F0, 8'hAA);

    // R4 alternate strap
    base_sel = 1'b1;
    bus_wr(16'h03F0, 8'h55);
    bus_wr(16'h03F0, 8'h55);
    bus_rd(16'h0371, 8'hFF, "R4 old base does not unlock");
    bus_wr(16'h0370, 8'h55);
    bus_wr(16'h0370, 8'h55);
    bus_wr(16'h0370, 8'h20);
    bus_rd(16'h0371, 8'h02, "R4 ident at 0x371");
    bus_rd(16'h03F1, 8'hFF, "R4 foreign address reads FF");
    bus_wr(16'h03F1, 8'h07);
    bus_rd(16'h0370, 8'h20, "R4 foreign write ignored");
    bus_wr(16'h0370, 8'hAA);
    bus_rd(16'h0370, 8'hFF, "R2 index port after close");

    // R12 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    check("R12 act cleared", 256'(dev_act), 256'(0));
    check("R12 aux cleared", 256'(dev_aux), 256'(0));
    check("R12 pwr cleared", 256'(pwr_en), 256'(0));
    bus_rd(16'h0371, 8'hFF, "R12 run mode after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule